// File: doc/BRIEF.md
# Level-to-pulse legacy interrupt merger

This block folds four level-sensitive legacy interrupt lines into a single interrupt output that pulses instead of holding a level. The host controller receiving that output sees one pulse per event. Each line has an enable bit and a sticky pending bit. When an enabled line goes from low to high, its pending bit is set and the output pulses once.

Software reads the pending bits to find the lines that need service and clears them by writing ones. After it services a line, it writes that line's index to an end-of-interrupt register. The block then samples the named line again. If the line is still high, the block sets its pending bit again and pulses again. A line that stays asserted therefore keeps being serviced, even though the output carries only edges.

The lines are taken as synchronous to `clk`. The reset input is asynchronous and active-low, and must be released in step with the clock by the surrounding logic.

Top module: `intx_pulse_merge`

## Requirements
- R1: While reset is asserted, and directly after it, the enable bits and pending bits read zero and the pulse output is low.
- R2: A low-to-high change on an enabled line sets that line's pending bit. The pulse output is then high for exactly one cycle, in the cycle after the edge is sampled.
- R3: A line that stays high causes no further pulse and does not change its pending bit until an end-of-interrupt write names it.
- R4: A line whose enable bit is zero never sets its pending bit and never causes a pulse. This holds even when an end-of-interrupt write names it.
- R5: A write of value v (0 to 3) to offset 0x010 names line 3-v. If that line is high and enabled, its pending bit is set and one pulse follows. If the line is low, nothing happens.
- R6: An end-of-interrupt write whose value is greater than 3 has no effect on the pending bits or on the pulse output.
- R7: A write to offset 0x700 clears each pending bit i whose data bit i is 1 and leaves the other pending bits unchanged. A new event on a line in the same cycle keeps that line's bit set.
- R8: Events on several lines in one cycle, whether edges or end-of-interrupt re-checks, produce a single one-cycle pulse. Every pending bit involved is set.
- R9: Offset 0x100 holds the enable bits in data bits 3:0, and bit i enables line i. The register is read and write, and bits 31:4 read as zero.
- R10: Offset 0x500 returns the pending bits in bits 3:0, and writes to it are ignored. Reads of offsets 0x010, 0x700 and every unmapped offset return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl_i | input | 4 | Legacy interrupt levels, bit i is line i |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse |

## Verification
A stale copy of a line's previous level appears within one cycle of the next level change, as a missing pulse or an extra pulse. A pending bit that is stuck or set wrongly shows on the next read of offset 0x500. A wrong index mapping in the end-of-interrupt decode shows at once: the pulse answers the wrong line, and the wrong pending bit is set in the cycle after the write. The bench sweeps every enable mask against every level pattern, and repeats each combination with every end-of-interrupt value from 0 to 5, so each of these faults appears in a single sweep step.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;

  localparam int unsigned OFS_EOI   = 'h010;
  localparam int unsigned OFS_ENA   = 'h100;
  localparam int unsigned OFS_PEND  = 'h500;
  localparam int unsigned OFS_CLR   = 'h700;
endpackage

// File: rtl/intx_src_cell.sv
module intx_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic en_i,
  input  logic eoi_hit_i,
  input  logic clr_i,
  output logic pend_o,
  output logic fire_o
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = lvl_i & ~prev_q;
    fire_o = en_i & (rise | (eoi_hit_i & lvl_i));
    prev_d = lvl_i;
    pend_d = fire_o | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R4
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_i));

  // R5
  eoi_resets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit_i && en_i && lvl_i) |=> pend_q);

  // R7
  clear_low_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !lvl_i) |=> !pend_q);

  // R3
  steady_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && lvl_i && !eoi_hit_i && !clr_i) |=> $stable(pend_q));
endmodule

// File: rtl/intx_pulse_gen.sv
module intx_pulse_gen #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] fire_i,
  output logic            pulse_o
);
  logic pulse_q, pulse_d;

  always_comb pulse_d = |fire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/intx_pulse_merge.sv
module intx_pulse_merge
  import intx_pkg::*;
#(
  parameter int unsigned NSRC = NUM_LINES,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lvl_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            irq_pulse_o
);
  localparam logic [AW-1:0] A_EOI  = AW'(OFS_EOI);
  localparam logic [AW-1:0] A_ENA  = AW'(OFS_ENA);
  localparam logic [AW-1:0] A_PEND = AW'(OFS_PEND);
  localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);

  logic            wr_eoi, wr_ena, wr_clr;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] eoi_hit, clr_mask, pend, fire;

  always_comb begin
    wr_eoi   = bus_wr_i && (bus_addr_i == A_EOI);
    wr_ena   = bus_wr_i && (bus_addr_i == A_ENA);
    wr_clr   = bus_wr_i && (bus_addr_i == A_CLR);
    en_d     = wr_ena ? bus_wdata_i[NSRC-1:0] : en_q;
    clr_mask = wr_clr ? bus_wdata_i[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_line
    // the end-of-interrupt value for line g is NSRC-1-g
    assign eoi_hit[g] = wr_eoi && (bus_wdata_i == DW'(NSRC - 1 - g));

    intx_src_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (irq_lvl_i[g]),
      .en_i      (en_q[g]),
      .eoi_hit_i (eoi_hit[g]),
      .clr_i     (clr_mask[g]),
      .pend_o    (pend[g]),
      .fire_o    (fire[g])
    );
  end

  intx_pulse_gen #(.NSRC(NSRC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire),
    .pulse_o (irq_pulse_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_ENA)       bus_rdata_o[NSRC-1:0] = en_q;
    else if (bus_addr_i == A_PEND) bus_rdata_o[NSRC-1:0] = pend;
  end

  // R2
  pulse_has_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> (pend != '0));

  // R9
  upper_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DW-1:NSRC] == '0);

  // R4
  pend_within_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~en_q) == '0) |=> ((pend & ~$past(en_q)) == '0) || $past(wr_ena));
endmodule

// File: tb/intx_pulse_merge_tb.sv
module intx_pulse_merge_tb;
  logic        clk;
  logic        rst_n;
  logic [3:0]  lvl;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_pulse;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  intx_pulse_merge u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lvl_i   (lvl),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_pulse_o (irq_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  ex;
    rst_n = 1'b0; lvl = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) tick();
    chk("R1 pulse in reset", {31'd0, irq_pulse}, 32'd0);
    rd(12'h100, r); chk("R1 enable in reset", r, 32'd0);
    rd(12'h500, r); chk("R1 pending in reset", r, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 pulse after reset", {31'd0, irq_pulse}, 32'd0);
    rd(12'h500, r); chk("R1 pending after reset", r, 32'd0);

    // R9 enable register
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, r); chk("R9 enable readback", r, 32'h0000_000F);
    wr(12'h100, 32'h0000_0005);
    rd(12'h100, r); chk("R9 enable readback 5", r, 32'h0000_0005);

    // R10 unmapped and write-ignored offsets
    wr(12'h500, 32'hF); wr(12'h104, 32'hF); wr(12'h200, 32'hF);
    rd(12'h500, r); chk("R10 pending not writable", r, 32'd0);
    rd(12'h100, r); chk("R10 enable untouched", r, 32'h5);
    rd(12'h200, r); chk("R10 unmapped read", r, 32'd0);
    rd(12'h010, r); chk("R10 eoi reads zero", r, 32'd0);
    rd(12'h700, r); chk("R10 clear reads zero", r, 32'd0);

    // R2 R3 R4 R8 sweep of enable mask against edge pattern
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        lvl = '0;
        wr(12'h100, 32'(m));
        wr(12'h700, 32'hF);
        tick();
        lvl = 4'(p);
        tick();
        ex = 4'(m & p);
        chk("R2 R8 pulse on edge", {31'd0, irq_pulse}, {31'd0, |ex});
        rd(12'h500, r); chk("R2 R4 R8 pending on edge", r, {28'd0, ex});
        tick();
        chk("R2 R3 pulse one cycle", {31'd0, irq_pulse}, 32'd0);
        tick();
        chk("R3 no pulse while held", {31'd0, irq_pulse}, 32'd0);
        rd(12'h500, r); chk("R3 pending kept", r, {28'd0, ex});
      end
    end

    // R4 R5 R6 sweep of end-of-interrupt values
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        lvl = '0;
        wr(12'h100, 32'(m));
        tick();
        lvl = 4'(p);
        tick(); tick();
        wr(12'h700, 32'hF);
        for (int v = 0; v < 6; v++) begin
          wr(12'h010, 32'(v));
          ex = '0;
          if (v < 4) ex[3 - v] = m[3 - v] & p[3 - v];
          chk("R5 R6 R4 eoi pulse", {31'd0, irq_pulse}, {31'd0, |ex});
          rd(12'h500, r); chk("R5 R6 R4 eoi pending", r, {28'd0, ex});
          wr(12'h700, 32'hF);
          chk("R5 eoi pulse one cycle", {31'd0, irq_pulse}, 32'd0);
        end
      end
    end

    // R6 large value
    lvl = '0; wr(12'h100, 32'hF); tick(); lvl = 4'hF; tick(); tick();
    wr(12'h700, 32'hF);
    wr(12'h010, 32'h0000_0100);
    chk("R6 big eoi value no pulse", {31'd0, irq_pulse}, 32'd0);
    rd(12'h500, r); chk("R6 big eoi value no pending", r, 32'd0);

    // R7 partial clear and set-over-clear
    lvl = '0; tick(); wr(12'h700, 32'hF);
    lvl = 4'b1010; tick(); tick();
    wr(12'h700, 32'h2);
    rd(12'h500, r); chk("R7 partial clear", r, 32'h8);
    lvl = 4'b1011;
    wr(12'h700, 32'h9);
    chk("R7 edge during clear pulses", {31'd0, irq_pulse}, 32'd1);
    rd(12'h500, r); chk("R7 set wins over clear", r, 32'h1);

    // R8 edge and eoi in the same cycle
    lvl = 4'b0001; tick(); wr(12'h700, 32'hF); tick();
    lvl = 4'b0011;
    wr(12'h010, 32'd3);
    chk("R8 merged pulse", {31'd0, irq_pulse}, 32'd1);
    rd(12'h500, r); chk("R8 both pending", r, 32'h3);
    tick();
    chk("R8 merged pulse one cycle", {31'd0, irq_pulse}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule